// File: doc/BRIEF.md
# Outbound MMIO Window Partition Decoder

The block sits on the outbound path of a PCIe host bridge. Each CPU-side MMIO address is matched against one narrow translating window and a bank of wide windows. For every access it returns the PCIe address to emit, the isolation group that owns the target, and whether the access may go out. Windows are naturally aligned power-of-two regions. Each window can be split into 256 equal segments, so that different devices behind the bridge can fall into different isolation groups.

In the narrow window, the address bits above the window size are swapped for a programmed PCIe base. A 256-entry table turns the segment index into a group. The wide windows pass the address through unchanged, except that they can optionally overwrite the top 14 address bits. A wide window either gives one fixed group to its whole range, or it uses the segment index directly as the group. When the resolved group is frozen, the access is reported as blocked rather than forwarded. The decode result is registered and appears one cycle after the request.

Top module: `owp_decoder`

## Requirements
- R1: The narrow window hits an address when it is enabled and the address bits at and above bit `size_log2` equal those of its base. A disabled narrow window never hits.
- R2: On a narrow hit, `rsp_addr` takes the programmed PCIe base with its low `size_log2` bits replaced by the same bits of the CPU address.
- R3: On a narrow hit, the segment index is address bits `[size_log2-1 : size_log2-8]`. `rsp_group` is the segment-map table entry at that index.
- R4: On a wide hit, `rsp_addr` equals the CPU address. When top replacement is enabled for that window, address bits `[ADDR_W-1 : ADDR_W-14]` are replaced by bits `[ADDR_W-1 : ADDR_W-14]` of the window's programmed translation value.
- R5: A hit in an unsegmented wide window reports the window's programmed group for every address in it.
- R6: A hit in a segmented wide window reports the segment index, computed as in R3 with that window's size, as the group.
- R7: Among matching enabled windows, the narrow window wins, then the wide window with the lowest index. `rsp_win` is 0 for the narrow window and k+1 for wide window k.
- R8: An address that matches no enabled window gives `rsp_unmapped=1`, `rsp_fwd=0`, `rsp_blocked=0`, and zero `rsp_group`, `rsp_win` and `rsp_addr`.
- R9: A hit whose group has its bit set in `freeze_mask` gives `rsp_blocked=1` and `rsp_fwd=0`, and still reports the group, window and translated address. A hit on an unfrozen group gives `rsp_fwd=1`.
- R10: A configuration write is captured on the clock edge where `cfg_wr` is high, and it governs requests presented from the next cycle on. Target codes are: 0 for narrow window control, 1 for a segment-map entry, 2 for wide window control. Code 3 is ignored, and a wide write whose index is `NWIDE` or more is ignored.
- R11: A request presented with `req_valid` at one clock edge is answered with `rsp_valid=1` after that edge. In cycles without a request, `rsp_valid` and every response field are 0.
- R12: Reset disables every window, clears the segment map, and drives all response outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | 0 narrow control, 1 segment-map entry, 2 wide control, 3 none |
| cfg_index | input | 8 | Segment-map entry index or wide window index |
| cfg_en | input | 1 | Window enable |
| cfg_seg | input | 1 | Wide window segmented mode |
| cfg_xlat_en | input | 1 | Wide window top-bit replacement enable |
| cfg_size_log2 | input | 6 | log2 of window size in bytes (8 or more) |
| cfg_base | input | ADDR_W | Window CPU base, aligned to size |
| cfg_xlat | input | ADDR_W | Narrow PCIe base, or wide top-bit replacement value |
| cfg_group | input | 8 | Wide fixed group, or segment-map entry value |
| freeze_mask | input | 256 | One bit per group, set when frozen |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | CPU address to decode |
| rsp_valid | output | 1 | Response present |
| rsp_fwd | output | 1 | Access may be forwarded |
| rsp_blocked | output | 1 | Access hit a frozen group |
| rsp_unmapped | output | 1 | No window matched |
| rsp_win | output | $clog2(NWIDE+1) | Winning window number |
| rsp_group | output | 8 | Owning group |
| rsp_addr | output | ADDR_W | PCIe address |

## Verification
A corrupt base, size or mode in a window register shows up on the first request that lands near that window. The symptom is a wrong hit or miss, a PCIe address with the wrong upper bits, or a group that drifts across segment boundaries. Each of these is visible one cycle after the request. A stale segment-map entry only appears when that exact segment is accessed, so the stimulus touches both the lowest and the highest segments. A wrong priority choice shows only where windows overlap, and appears as a wrong `rsp_win` together with a wrong group.

// File: rtl/owp_pkg.sv
package owp_pkg;

  localparam int SEG_W = 8;
  localparam int TOP_W = 14;

  typedef logic [63:0] addr64_t;

  typedef enum logic [1:0] {
    CFG_NARROW = 2'd0,
    CFG_SEGMAP = 2'd1,
    CFG_WIDE   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_target_e;

  typedef struct packed {
    logic       en;
    logic [5:0] lg;
    addr64_t    base;
    addr64_t    xlat;
  } narrow_cfg_t;

  typedef struct packed {
    logic             en;
    logic             seg;
    logic             xen;
    logic [5:0]       lg;
    addr64_t          base;
    logic [TOP_W-1:0] top;
    logic [SEG_W-1:0] grp;
  } wide_cfg_t;

  // mask of the offset bits inside a window of 2**lg bytes
  function automatic addr64_t low_mask(input logic [5:0] lg);
    return (64'd1 << lg) - 64'd1;
  endfunction

  // address lies in the aligned window that contains base
  function automatic logic in_window(input addr64_t a, input addr64_t b,
                                     input logic [5:0] lg);
    return ((a ^ b) & ~low_mask(lg)) == 64'd0;
  endfunction

  // the eight address bits just below the window size boundary
  function automatic logic [SEG_W-1:0] seg_of(input addr64_t a,
                                              input logic [5:0] lg);
    addr64_t sh;
    sh = a >> (lg - 6'(SEG_W));
    return sh[SEG_W-1:0];
  endfunction

  // high part from hi, offset part from lo
  function automatic addr64_t splice(input addr64_t hi, input addr64_t lo,
                                     input logic [5:0] lg);
    return (hi & ~low_mask(lg)) | (lo & low_mask(lg));
  endfunction

endpackage

// File: rtl/owp_cfg_store.sv
module owp_cfg_store
  import owp_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int NWIDE  = 16,
  localparam int NSEG   = 1 << SEG_W,
  localparam int WIDX_W = (NWIDE > 1) ? $clog2(NWIDE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_target,
  input  logic [7:0]        cfg_index,
  input  logic              cfg_en,
  input  logic              cfg_seg,
  input  logic              cfg_xlat_en,
  input  logic [5:0]        cfg_size_log2,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_xlat,
  input  logic [SEG_W-1:0]  cfg_group,
  output narrow_cfg_t       ncfg,
  output logic [SEG_W-1:0]  seg_map [NSEG],
  output wide_cfg_t         wcfg [NWIDE]
);

  cfg_target_e tgt;
  logic        wide_idx_ok;

  assign tgt         = cfg_target_e'(cfg_target);
  assign wide_idx_ok = int'(cfg_index) < NWIDE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncfg <= '0;
      for (int i = 0; i < NSEG; i++) seg_map[i] <= '0;
      for (int k = 0; k < NWIDE; k++) wcfg[k] <= '0;
    end else if (cfg_wr) begin
      unique case (tgt)
        CFG_NARROW: ncfg <= '{en: cfg_en, lg: cfg_size_log2,
                              base: 64'(cfg_base), xlat: 64'(cfg_xlat)};
        CFG_SEGMAP: seg_map[cfg_index] <= cfg_group;
        CFG_WIDE: begin
          if (wide_idx_ok)
            wcfg[cfg_index[WIDX_W-1:0]] <= '{en: cfg_en, seg: cfg_seg,
                                            xen: cfg_xlat_en, lg: cfg_size_log2,
                                            base: 64'(cfg_base),
                                            top: cfg_xlat[ADDR_W-1 -: TOP_W],
                                            grp: cfg_group};
        end
        CFG_NONE: ;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/owp_wide_bank.sv
module owp_wide_bank
  import owp_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int NWIDE  = 16,
  localparam int WIDX_W = (NWIDE > 1) ? $clog2(NWIDE) : 1
) (
  input  addr64_t           addr,
  input  wide_cfg_t         wcfg [NWIDE],
  output logic              hit,
  output logic [WIDX_W-1:0] idx,
  output logic [SEG_W-1:0]  grp,
  output logic [ADDR_W-1:0] pa,
  output logic [NWIDE-1:0]  hit_vec
);

  for (genvar g = 0; g < NWIDE; g++) begin : g_match
    assign hit_vec[g] = wcfg[g].en && in_window(addr, wcfg[g].base, wcfg[g].lg);
  end

  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = NWIDE - 1; i >= 0; i--)
      if (hit_vec[i]) idx = WIDX_W'(i);
  end

  assign hit = |hit_vec;

  always_comb begin
    grp = wcfg[idx].seg ? seg_of(addr, wcfg[idx].lg) : wcfg[idx].grp;
    pa  = ADDR_W'(addr);
    if (wcfg[idx].xen) pa[ADDR_W-1 -: TOP_W] = wcfg[idx].top;
  end

endmodule

// File: rtl/owp_decoder.sv
module owp_decoder
  import owp_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int NWIDE  = 16,
  localparam int NSEG   = 1 << SEG_W,
  localparam int WIDX_W = (NWIDE > 1) ? $clog2(NWIDE) : 1,
  localparam int WIN_W  = $clog2(NWIDE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_target,
  input  logic [7:0]        cfg_index,
  input  logic              cfg_en,
  input  logic              cfg_seg,
  input  logic              cfg_xlat_en,
  input  logic [5:0]        cfg_size_log2,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_xlat,
  input  logic [SEG_W-1:0]  cfg_group,
  input  logic [NSEG-1:0]   freeze_mask,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_fwd,
  output logic              rsp_blocked,
  output logic              rsp_unmapped,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [SEG_W-1:0]  rsp_group,
  output logic [ADDR_W-1:0] rsp_addr
);

  narrow_cfg_t       ncfg;
  logic [SEG_W-1:0]  seg_map [NSEG];
  wide_cfg_t         wcfg [NWIDE];

  owp_cfg_store #(.ADDR_W(ADDR_W), .NWIDE(NWIDE)) u_cfg (
    .clk, .rst_n, .cfg_wr, .cfg_target, .cfg_index, .cfg_en, .cfg_seg,
    .cfg_xlat_en, .cfg_size_log2, .cfg_base, .cfg_xlat, .cfg_group,
    .ncfg, .seg_map, .wcfg
  );

  // named decode events
  addr64_t           a64;
  logic              n_hit;
  logic [SEG_W-1:0]  n_seg;
  logic              w_hit;
  logic [WIDX_W-1:0] w_idx;
  logic [SEG_W-1:0]  w_grp;
  logic [ADDR_W-1:0] w_pa;
  logic [NWIDE-1:0]  w_hit_vec;
  logic              any_hit;
  logic [SEG_W-1:0]  sel_grp;
  logic [ADDR_W-1:0] sel_pa;
  logic [WIN_W-1:0]  sel_win;
  logic              sel_frozen;

  assign a64   = 64'(req_addr);
  assign n_hit = ncfg.en && in_window(a64, ncfg.base, ncfg.lg);
  assign n_seg = seg_of(a64, ncfg.lg);

  owp_wide_bank #(.ADDR_W(ADDR_W), .NWIDE(NWIDE)) u_bank (
    .addr(a64), .wcfg, .hit(w_hit), .idx(w_idx), .grp(w_grp), .pa(w_pa),
    .hit_vec(w_hit_vec)
  );

  assign any_hit    = n_hit || w_hit;
  assign sel_grp    = n_hit ? seg_map[n_seg] : w_grp;
  assign sel_pa     = n_hit ? ADDR_W'(splice(ncfg.xlat, a64, ncfg.lg)) : w_pa;
  assign sel_win    = n_hit ? '0 : WIN_W'(w_idx) + WIN_W'(1);
  assign sel_frozen = freeze_mask[sel_grp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fwd      <= 1'b0;
      rsp_blocked  <= 1'b0;
      rsp_unmapped <= 1'b0;
      rsp_win      <= '0;
      rsp_group    <= '0;
      rsp_addr     <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_fwd      <= req_valid && any_hit && !sel_frozen;
      rsp_blocked  <= req_valid && any_hit && sel_frozen;
      rsp_unmapped <= req_valid && !any_hit;
      rsp_win      <= (req_valid && any_hit) ? sel_win : '0;
      rsp_group    <= (req_valid && any_hit) ? sel_grp : '0;
      rsp_addr     <= (req_valid && any_hit) ? sel_pa  : '0;
    end
  end

  // ---------------- assertions ----------------
  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fwd && !rsp_blocked && !rsp_unmapped
                    && rsp_addr == '0));

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_fwd, rsp_blocked, rsp_unmapped}));

  p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmapped) |-> (rsp_group == '0 && rsp_win == '0
                                     && rsp_addr == '0));

  p_blocked_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_blocked && $stable(freeze_mask)) |-> freeze_mask[rsp_group]);

  p_fwd_thawed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fwd && $stable(freeze_mask)) |-> !freeze_mask[rsp_group]);

  p_narrow_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && n_hit) |=> (rsp_win == '0 && !rsp_unmapped));

  p_wide_hit_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !n_hit && w_hit_vec != '0) |=> rsp_win != '0);

endmodule

// File: tb/sim_owp_decoder.sv
module sim_owp_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [1:0]      cfg_target = '0;
  logic [7:0]      cfg_index = '0;
  logic            cfg_en = 1'b0, cfg_seg = 1'b0, cfg_xlat_en = 1'b0;
  logic [5:0]      cfg_size_log2 = '0;
  logic [AW-1:0]   cfg_base = '0, cfg_xlat = '0;
  logic [7:0]      cfg_group = '0;
  logic [255:0]    freeze_mask = '0;
  logic            req_valid = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic            rsp_valid, rsp_fwd, rsp_blocked, rsp_unmapped;
  logic [4:0]      rsp_win;
  logic [7:0]      rsp_group;
  logic [AW-1:0]   rsp_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  owp_decoder u0 (
    .clk, .rst_n, .cfg_wr, .cfg_target, .cfg_index, .cfg_en, .cfg_seg,
    .cfg_xlat_en, .cfg_size_log2, .cfg_base, .cfg_xlat, .cfg_group,
    .freeze_mask, .req_valid, .req_addr, .rsp_valid, .rsp_fwd, .rsp_blocked,
    .rsp_unmapped, .rsp_win, .rsp_group, .rsp_addr
  );

  // segment-map contents programmed by the bench
  function automatic logic [7:0] tgrp(input int i);
    return 8'(i * 7 + 3);
  endfunction

  typedef struct packed {
    logic [AW-1:0] a;
    logic [AW-1:0] pa;
    logic [7:0]    g;
    logic [4:0]    w;
    logic          m;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{48'h0_8000_1234, 48'h1_0000_1234, tgrp(0), 5'd0, 1'b0},
    '{48'h0_FF80_0010, 48'h1_7F80_0010, tgrp(255), 5'd0, 1'b0},
    '{48'h0_C123_4567, 48'h1_4123_4567, tgrp(int'(8'(48'hC123_4567 >> 23))), 5'd0, 1'b0},
    '{48'h0_7FFF_FFFF, 48'h0, 8'h00, 5'd0, 1'b1},
    '{48'h1_0000_0000, 48'h0, 8'h00, 5'd0, 1'b1},
    '{48'h10_8000_0000, 48'h10_8000_0000, 8'h21, 5'd1, 1'b0},
    '{48'h13_4000_0000, 48'h13_4000_0000, 8'h34, 5'd2, 1'b0},
    '{48'h1F_FFFF_FFFF, 48'h1F_FFFF_FFFF, 8'hFF, 5'd2, 1'b0},
    '{48'h21_2345_6788,
      (48'h5 << 34) | (48'h21_2345_6788 & ((48'h1 << 34) - 48'h1)),
      8'((48'h21_2345_6788 - 48'h20_0000_0000) >> 25), 5'd3, 1'b0},
    '{48'h22_0000_0000, 48'h0, 8'h00, 5'd0, 1'b1},
    '{48'h30_0000_0100, 48'h0, 8'h00, 5'd0, 1'b1},
    '{48'h40_3FFF_FFF0, 48'h40_3FFF_FFF0, 8'h77, 5'd16, 1'b0},
    '{48'h40_4000_0000, 48'h0, 8'h00, 5'd0, 1'b1}
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] t, input logic [7:0] idx, input logic en,
                    input logic sg, input logic xe, input logic [5:0] lg,
                    input logic [AW-1:0] b, input logic [AW-1:0] x,
                    input logic [7:0] g);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_target = t; cfg_index = idx; cfg_en = en; cfg_seg = sg;
    cfg_xlat_en = xe; cfg_size_log2 = lg; cfg_base = b; cfg_xlat = x;
    cfg_group = g;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // present one request; returns at the negedge where the response is held
  task automatic req(input logic [AW-1:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic m, input logic blk,
                       input logic [AW-1:0] pa, input logic [7:0] g,
                       input logic [4:0] w);
    logic [64:0] got, exp;
    got = {rsp_valid, rsp_fwd, rsp_blocked, rsp_unmapped, rsp_win, rsp_group,
           rsp_addr};
    exp = {1'b1, !m && !blk, blk, m, w, g, pa};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    logic [64:0] got;
    got = {rsp_valid, rsp_fwd, rsp_blocked, rsp_unmapped, rsp_win, rsp_group,
           rsp_addr};
    n_chk++;
    if (got !== '0) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, 65'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R11: watchdog expired, got hang expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R12: quiet outputs after reset, and no window decodes
    check_idle("R12 reset outputs");
    req(48'h0_8000_1234);
    check("R12 windows off after reset", 1'b1, 1'b0, '0, '0, '0);
    @(negedge clk);
    check_idle("R11 idle after request");

    // configuration
    wr(2'd0, 8'd0, 1'b1, 1'b0, 1'b0, 6'd31, 48'h0_8000_0000, 48'h1_0000_0000, 8'h0);
    for (int i = 0; i < 256; i++)
      wr(2'd1, 8'(i), 1'b0, 1'b0, 1'b0, 6'd0, '0, '0, tgrp(i));
    wr(2'd2, 8'd0, 1'b1, 1'b0, 1'b0, 6'd32, 48'h10_0000_0000, '0, 8'h21);
    wr(2'd2, 8'd1, 1'b1, 1'b1, 1'b0, 6'd36, 48'h10_0000_0000, '0, 8'h00);
    wr(2'd2, 8'd2, 1'b1, 1'b1, 1'b1, 6'd33, 48'h20_0000_0000, 48'h5 << 34, 8'h00);
    wr(2'd2, 8'd3, 1'b0, 1'b0, 1'b0, 6'd32, 48'h30_0000_0000, '0, 8'h44);
    wr(2'd2, 8'd15, 1'b1, 1'b0, 1'b0, 6'd30, 48'h40_0000_0000, '0, 8'h77);

    // vector table: R1 R2 R3 narrow, R4 R5 R6 R7 wide, R8 misses
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req(VECS[v].a);
      check(VECS[v].m ? "R8 miss" : (VECS[v].w == 0 ? "R2 R3 narrow" : "R4 R5 R6 wide"),
            VECS[v].m, 1'b0, VECS[v].pa, VECS[v].g, VECS[v].w);
    end

    // R9: frozen groups, wide segmented and narrow
    freeze_mask[8'h34] = 1'b1;
    @(negedge clk);
    req(48'h13_4000_0000);
    check("R9 wide frozen", 1'b0, 1'b1, 48'h13_4000_0000, 8'h34, 5'd2);
    freeze_mask[tgrp(0)] = 1'b1;
    req(48'h0_8000_1234);
    check("R9 narrow frozen", 1'b0, 1'b1, 48'h1_0000_1234, tgrp(0), 5'd0);
    freeze_mask = '0;
    req(48'h13_4000_0000);
    check("R9 thawed", 1'b0, 1'b0, 48'h13_4000_0000, 8'h34, 5'd2);

    // R10 R3: table rewrite seen by the very next request
    wr(2'd1, 8'd0, 1'b0, 1'b0, 1'b0, 6'd0, '0, '0, 8'hEE);
    req(48'h0_8000_1234);
    check("R10 R3 remap", 1'b0, 1'b0, 48'h1_0000_1234, 8'hEE, 5'd0);

    // R10: enabling wide window 3
    wr(2'd2, 8'd3, 1'b1, 1'b0, 1'b0, 6'd32, 48'h30_0000_0000, '0, 8'h44);
    req(48'h30_0000_0100);
    check("R10 R5 enable w3", 1'b0, 1'b0, 48'h30_0000_0100, 8'h44, 5'd4);

    // R10: wide index out of range is ignored
    wr(2'd2, 8'd16, 1'b1, 1'b0, 1'b0, 6'd32, 48'h50_0000_0000, '0, 8'h99);
    req(48'h50_0000_0000);
    check("R10 bad index", 1'b1, 1'b0, '0, '0, '0);

    // R10: target code 3 is ignored, narrow window unchanged
    wr(2'd3, 8'd0, 1'b0, 1'b0, 1'b0, 6'd32, 48'h50_0000_0000, '0, 8'h99);
    req(48'h0_8000_1234);
    check("R10 target 3", 1'b0, 1'b0, 48'h1_0000_1234, 8'hEE, 5'd0);
    req(48'h50_0000_0000);
    check("R10 target 3 miss", 1'b1, 1'b0, '0, '0, '0);

    // R7: with window 0 off, the overlapping window 1 takes over
    wr(2'd2, 8'd0, 1'b0, 1'b0, 1'b0, 6'd32, 48'h10_0000_0000, '0, 8'h21);
    req(48'h10_8000_0000);
    check("R7 fallthrough", 1'b0, 1'b0, 48'h10_8000_0000, 8'h08, 5'd2);

    // R1: disabled narrow window never hits
    wr(2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 6'd31, 48'h0_8000_0000, 48'h1_0000_0000, 8'h0);
    req(48'h0_8000_1234);
    check("R1 narrow off", 1'b1, 1'b0, '0, '0, '0);

    // R12: reset clears configured windows
    do_reset();
    req(48'h13_4000_0000);
    check("R12 wide cleared", 1'b1, 1'b0, '0, '0, '0);
    @(negedge clk);
    check_idle("R11 idle");

    finish_run();
  end

endmodule